// File: doc/BRIEF.md
# SPI controller interrupt status and enable unit

This unit keeps the interrupt state of a four-channel SPI controller. Each channel has two event strobes, transmit-empty and receive-full. A pulse on a strobe sets a sticky status bit. Software clears status bits by writing ones to them. A single level-sensitive interrupt line is asserted whenever any status bit is set and its matching enable bit is also set.

The unit also holds three small configuration registers:
- a system-test register;
- a module-control register;
- a one-bit wakeup enable.

The test-mode bit and the single-channel bit of module control are brought out as ports for the rest of the controller.

In system-test mode the unit can force every implemented status bit to one at once. While that mode is armed, software clears are held off. All registers are written through one write port and read through one combinational read port.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Reset values are: status, enable, system-test and wakeup enable all 0, module control 4, and `irq` low.
- R2: A pulse on `txe_set[n]` sets status bit 4*n. A pulse on `rxf_set[n]` sets status bit 4*n+2. Each bit then stays set until software clears it.
- R3: A write to status (select 0) clears every status bit whose data bit is 1. Bits written as 0 keep their value.
- R4: If a strobe sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R5: A write to enable (select 1) keeps only the implemented bits given by mask 0x1777F. All other enable bits read 0.
- R6: `irq` is registered. In every cycle it equals the OR of (status AND enable) as those registers stood in the previous cycle.
- R7: A status write has no effect while module-control bit 3 and system-test bit 11 are both 1.
- R8: A system-test write (select 3) with data bit 11 set, made while module-control bit 3 is already 1, sets status to 0x1777F.
- R9: A module-control write (select 4) with data bit 3 set, made while system-test bit 11 is already 1, sets status to 0x1777F.
- R10: System-test keeps data bits 11:0, module control keeps bits 3:0, and wakeup enable (select 2) keeps bit 0.
- R11: `test_mode` equals module-control bit 3 and `single_mode` equals module-control bit 0.
- R12: `rd_data` returns the register chosen by `rd_sel` (0 status, 1 enable, 2 wakeup, 3 system-test, 4 module control), zero-extended to 17 bits. Selects 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txe_set | input | 4 | Per-channel transmit-empty event strobes |
| rxf_set | input | 4 | Per-channel receive-full event strobes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register chosen for the write |
| wr_data | input | 17 | Write data |
| rd_sel | input | 3 | Register chosen for the read |
| rd_data | output | 17 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| test_mode | output | 1 | Module-control test bit |
| single_mode | output | 1 | Module-control single-channel bit |

## Verification
The assertions assume that at most one register write happens per cycle. They also assume that strobes and write data are valid at the rising edge, and they place no limit on how strobes and writes overlap.

The random stimulus writes to every select, including unused ones. It often raises several strobes together with a status clear in the same cycle. It biases module-control writes so that test mode is entered and left again, which exercises both force paths and the clear lock without leaving the unit locked.

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int NCH = 4,
  parameter logic [4*NCH:0] IMPL = 17'h1777F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   txe_set,
  input  logic [NCH-1:0]   rxf_set,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [4*NCH:0]   wr_data,
  input  logic [2:0]       rd_sel,
  output logic [4*NCH:0]   rd_data,
  output logic             irq,
  output logic             test_mode,
  output logic             single_mode
);
  localparam int SW = 4*NCH + 1;
  localparam logic [2:0] SEL_STAT = 3'd0, SEL_EN = 3'd1, SEL_WK = 3'd2,
                         SEL_SYST = 3'd3, SEL_CTRL = 3'd4;

  logic [SW-1:0] stat, en, hw_set;
  logic [11:0]   syst;
  logic [3:0]    ctrl;
  logic          wk;

  wire w_stat = wr_en && wr_sel == SEL_STAT;
  wire w_en   = wr_en && wr_sel == SEL_EN;
  wire w_wk   = wr_en && wr_sel == SEL_WK;
  wire w_syst = wr_en && wr_sel == SEL_SYST;
  wire w_ctrl = wr_en && wr_sel == SEL_CTRL;

  wire locked    = ctrl[3] & syst[11];
  wire force_all = (w_syst & ctrl[3] & wr_data[11]) | (w_ctrl & wr_data[3] & syst[11]);
  wire [SW-1:0] clr = (w_stat && !locked) ? wr_data : '0;

  always_comb begin
    hw_set = '0;
    for (int n = 0; n < NCH; n++) begin
      hw_set[4*n]   = txe_set[n];
      hw_set[4*n+2] = rxf_set[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
      syst <= '0;
      ctrl <= 4'd4;
      wk   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      stat <= force_all ? IMPL : (((stat & ~clr) | hw_set) & IMPL);
      if (w_en)   en   <= wr_data & IMPL;
      if (w_wk)   wk   <= wr_data[0];
      if (w_syst) syst <= wr_data[11:0];
      if (w_ctrl) ctrl <= wr_data[3:0];
      irq <= |(stat & en);
    end
  end

  assign test_mode   = ctrl[3];
  assign single_mode = ctrl[0];

  always_comb begin
    case (rd_sel)
      SEL_STAT: rd_data = stat;
      SEL_EN:   rd_data = en;
      SEL_WK:   rd_data = {{(SW-1){1'b0}}, wk};
      SEL_SYST: rd_data = {{(SW-12){1'b0}}, syst};
      SEL_CTRL: rd_data = {{(SW-4){1'b0}}, ctrl};
      default:  rd_data = '0;
    endcase
  end
endmodule

module spi_irq_ctrl_chk #(
  parameter int NCH = 4,
  parameter logic [4*NCH:0] IMPL = 17'h1777F
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] txe_set,
  input logic [NCH-1:0] rxf_set,
  input logic           wr_en,
  input logic [2:0]     wr_sel,
  input logic [4*NCH:0] wr_data,
  input logic [4*NCH:0] stat,
  input logic [4*NCH:0] en,
  input logic [11:0]    syst,
  input logic [3:0]     ctrl,
  input logic           irq
);
  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(stat & en)));

  p_en_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd1) |=> en == ($past(wr_data) & IMPL));

  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && ctrl[3] && syst[11]) |=> (stat & $past(stat)) == $past(stat));

  p_force_syst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && ctrl[3] && wr_data[11]) |=> stat == IMPL);

  p_force_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4 && wr_data[3] && syst[11]) |=> stat == IMPL);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_txe_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txe_set[n] |=> stat[4*n]);
    p_rxf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_set[n] |=> stat[4*n+2]);
  end
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.NCH(NCH), .IMPL(IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .txe_set(txe_set), .rxf_set(rxf_set),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stat(stat),
  .en(en), .syst(syst), .ctrl(ctrl), .irq(irq));

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
  localparam int PERIOD = 20;
  localparam logic [16:0] IMPL = 17'h1777F;

  logic clk = 0, rst_n = 0;
  logic [3:0] txe_set = 0, rxf_set = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [16:0] wr_data = 0, rd_data;
  logic irq, test_mode, single_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [16:0] m_stat, m_en;
  logic [11:0] m_syst;
  logic [3:0]  m_ctrl;
  logic        m_wk, m_irq;

  spi_irq_ctrl uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [16:0] ev_bits(logic [3:0] t, logic [3:0] r);
    logic [16:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[4*n] = t[n];
      v[4*n+2] = r[n];
    end
    return v;
  endfunction

  function automatic logic [16:0] next_stat(logic [16:0] st, logic we, logic [2:0] sel,
      logic [16:0] d, logic [3:0] t, logic [3:0] r, logic [3:0] c, logic [11:0] sy);
    logic [16:0] v = st;
    if (we && sel == 3 && c[3] && d[11]) return IMPL;
    if (we && sel == 4 && d[3] && sy[11]) return IMPL;
    if (we && sel == 0 && !(c[3] && sy[11])) v = v & ~d;
    return (v | ev_bits(t, r)) & IMPL;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [16:0] exp [8];
    exp[0] = m_stat; exp[1] = m_en; exp[2] = {16'b0, m_wk};
    exp[3] = {5'b0, m_syst}; exp[4] = {13'b0, m_ctrl};
    exp[5] = 0; exp[6] = 0; exp[7] = 0;
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      case (s)
        0: chk("R3 status", rd_data, exp[s]);
        1: chk("R5 enable", rd_data, exp[s]);
        2, 3, 4: chk("R10 config", rd_data, exp[s]);
        default: chk("R12 unused select", rd_data, exp[s]);
      endcase
    end
    chk("R6 irq", irq, m_irq);
    chk("R11 test_mode", test_mode, m_ctrl[3]);
    chk("R11 single_mode", single_mode, m_ctrl[0]);
  endtask

  task automatic step(logic we, logic [2:0] sel, logic [16:0] d, logic [3:0] t, logic [3:0] r);
    logic [16:0] ns;
    wr_en = we; wr_sel = sel; wr_data = d; txe_set = t; rxf_set = r;
    ns = next_stat(m_stat, we, sel, d, t, r, m_ctrl, m_syst);
    @(posedge clk);
    #1;
    m_irq = |(m_stat & m_en);
    m_stat = ns;
    if (we && sel == 1) m_en = d & IMPL;
    if (we && sel == 2) m_wk = d[0];
    if (we && sel == 3) m_syst = d[11:0];
    if (we && sel == 4) m_ctrl = d[3:0];
    wr_en = 0; txe_set = 0; rxf_set = 0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    m_stat = 0; m_en = 0; m_syst = 0; m_ctrl = 4; m_wk = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check_all();
    chk("R1 ctrl reset", {28'b0, m_ctrl}, 32'd4);

    // R2: strobes set the channel bits
    step(0, 0, 0, 4'b0101, 4'b1000);
    chk("R2 channel bits", m_stat, 17'h04101);
    // R3: partial clear
    step(1, 0, 17'h00001, 0, 0);
    chk("R3 partial clear", m_stat, 17'h04100);
    // R4: set and clear of the same bit in one cycle
    step(1, 0, 17'h00100, 4'b0100, 0);
    chk("R4 set wins", m_stat, 17'h04100);
    // R5: enable masking, R6 irq latency
    step(1, 1, 17'h1FFFF, 0, 0);
    chk("R5 enable mask", m_en, IMPL);
    step(0, 0, 0, 0, 0);
    chk("R6 irq high", {31'b0, irq}, 32'd1);
    // R8: force through system-test write
    step(1, 4, 17'h00008, 0, 0);
    step(1, 3, 17'h1FFFF, 0, 0);
    chk("R8 force via syst", m_stat, IMPL);
    // R7: clear blocked while locked
    step(1, 0, 17'h1FFFF, 0, 0);
    chk("R7 clear blocked", m_stat, IMPL);
    // leave test mode, clear all
    step(1, 4, 17'h00000, 0, 0);
    step(1, 0, 17'h1FFFF, 0, 0);
    chk("R3 clear all", m_stat, 17'h0);
    // R9: force through module-control write
    step(1, 4, 17'h0000F, 0, 0);
    chk("R9 force via ctrl", m_stat, IMPL);
    chk("R11 test_mode set", {31'b0, test_mode}, 32'd1);
    step(1, 3, 17'h00000, 0, 0);
    step(1, 4, 17'h00004, 0, 0);
    step(1, 0, 17'h1FFFF, 0, 0);
    step(1, 2, 17'h1FFFF, 0, 0);
    chk("R10 wakeup bit", {31'b0, m_wk}, 32'd1);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] sel;
      logic [16:0] d;
      sel = 3'($urandom % 8);
      d = 17'($urandom);
      if (sel == 4) d[3] = ($urandom % 4) == 0;
      step(($urandom % 10) < 6, sel, d, 4'($urandom & $urandom), 4'($urandom & $urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule